// File: doc/BRIEF.md
# Dual-Modulus Prescaler Controller

This block sits in the feedback path of a frequency synthesizer, behind an external prescaler that divides the oscillator by either P or P+1. It is clocked by the prescaler's output. It runs two down-counters side by side: a main counter loaded with a 10-bit value N and a swallow counter loaded with a 6-bit value A. The modulus-select output stays low, which asks the prescaler for P+1, while the swallow counter is still running. It then goes high, which asks for P, for the rest of the main count.

Each feedback cycle spans N prescaler output periods. In the last of these periods the block raises a one-period feedback pulse, which a phase detector compares against the reference. The oscillator is therefore divided by N·P + A overall. The program values are taken only when the counters reload. A swallow value larger than N raises an error flag for that cycle and is treated as equal to N.

Top module: `dual_mod_ctrl`

## Requirements
- R1: A feedback cycle lasts N periods of `clk_fin` (N ≥ 3). `fb_pulse` is high during exactly one of them, the last one, and never for two periods in a row.
- R2: In each cycle `mod_ctl` is low (0 = prescaler divides by P+1) for the first A periods. It is high (1 = prescaler divides by P) for the remaining N−A periods and does not fall before the cycle ends.
- R3: When A = 0, `mod_ctl` is high for every period of the cycle.
- R4: With a prescaler that divides by P+1 while `mod_ctl` is 0 and by P while it is 1, one feedback cycle spans exactly N·P + A prescaler input cycles.
- R5: `n_prog` and `a_prog` are sampled only at a reload, which is the rising edge that ends a cycle, or while `rst` is held. A change in the middle of a cycle does not alter that cycle; it takes effect from the next cycle.
- R6: When A > N at a reload, `swallow_err` is 1 for the whole cycle that follows and A is treated as N, so `mod_ctl` stays low for all N periods. Otherwise `swallow_err` is 0. The flag changes only at a reload.
- R7: `rst` is synchronous and active high. While it is held, both counters keep their programmed values: `fb_pulse` is 0, `mod_ctl` equals (A = 0), and `swallow_err` equals (A > N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fin | input | 1 | Prescaler output; every rising edge is one counted period |
| rst | input | 1 | Synchronous active-high reset |
| n_prog | input | 10 | Main division value N, 3 to 1023 |
| a_prog | input | 6 | Swallow count A, 0 to 63 |
| mod_ctl | output | 1 | Modulus select: 0 asks for P+1, 1 asks for P |
| fb_pulse | output | 1 | One-period pulse in the last period of each cycle |
| swallow_err | output | 1 | Set for a cycle whose program had A > N |

## Verification
The properties assume that N is at least 3, so the main counter can never reach its terminal count on two edges in a row, and that the program inputs are settled at every `clk_fin` rising edge. The stimulus uses N values from 3 upward. It changes the program only at falling edges of the fast oscillator clock while the prescaler output is low, so a reload never samples a value that is still changing. The bench includes a behavioural P/P+1 prescaler driven by that oscillator clock. Because of this, the division totals are measured in oscillator cycles against N·P + A, rather than inferred from the controller's own outputs.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int PMC_N_W = 10;
    localparam int PMC_A_W = 6;

    // Which prescaler modulus the controller is asking for
    typedef enum logic {
        MC_SWALLOW = 1'b0,  // prescaler divides by P+1
        MC_NORMAL  = 1'b1   // prescaler divides by P
    } mc_phase_e;

    function automatic logic phase_to_pin(input mc_phase_e ph);
        return (ph == MC_NORMAL);
    endfunction
endpackage

// File: rtl/pmc_swallow_clamp.sv
module pmc_swallow_clamp #(
    parameter int N_W = 10,
    parameter int A_W = 6
) (
    input  logic [N_W-1:0] n_val,
    input  logic [A_W-1:0] a_val,
    output logic [A_W-1:0] a_eff,
    output logic           over
);
    localparam int CMP_W = (N_W > A_W) ? N_W : A_W;

    logic [CMP_W-1:0] n_ext;
    logic [CMP_W-1:0] a_ext;

    assign n_ext = CMP_W'(n_val);
    assign a_ext = CMP_W'(a_val);
    assign over  = (a_ext > n_ext);
    // when over is set, n is below a and therefore fits the swallow width
    assign a_eff = over ? n_ext[A_W-1:0] : a_val;
endmodule

// File: rtl/pmc_main_count.sv
module pmc_main_count #(
    parameter int N_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_val,
    output logic           terminal
);
    localparam logic [N_W-1:0] ONE = N_W'(1);

    logic [N_W-1:0] n_cnt;

    // periods left in the cycle, the current one included
    assign terminal = (n_cnt <= ONE);

    always_ff @(posedge clk) begin
        if (rst || terminal) begin
            n_cnt <= n_val;
        end else begin
            n_cnt <= n_cnt - ONE;
        end
    end
endmodule

// File: rtl/pmc_swallow_count.sv
module pmc_swallow_count
    import pmc_pkg::*;
#(
    parameter int A_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [A_W-1:0] a_eff,
    output mc_phase_e      phase
);
    localparam logic [A_W-1:0] ONE = A_W'(1);

    logic [A_W-1:0] a_cnt;

    assign phase = (a_cnt == '0) ? MC_NORMAL : MC_SWALLOW;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            a_cnt <= a_eff;
        end else if (a_cnt != '0) begin
            a_cnt <= a_cnt - ONE;
        end
    end
endmodule

// File: rtl/dual_mod_ctrl.sv
module dual_mod_ctrl
    import pmc_pkg::*;
#(
    parameter int N_W = PMC_N_W,
    parameter int A_W = PMC_A_W
) (
    input  logic           clk_fin,
    input  logic           rst,
    input  logic [N_W-1:0] n_prog,
    input  logic [A_W-1:0] a_prog,
    output logic           mod_ctl,
    output logic           fb_pulse,
    output logic           swallow_err
);
    logic [A_W-1:0] a_eff;
    logic           a_over;
    logic           reload;
    mc_phase_e      phase;
    logic           err_q;

    pmc_swallow_clamp #(.N_W(N_W), .A_W(A_W)) u_clamp (
        .n_val (n_prog),
        .a_val (a_prog),
        .a_eff (a_eff),
        .over  (a_over)
    );

    pmc_main_count #(.N_W(N_W)) u_main (
        .clk      (clk_fin),
        .rst      (rst),
        .n_val    (n_prog),
        .terminal (reload)
    );

    pmc_swallow_count #(.A_W(A_W)) u_swallow (
        .clk   (clk_fin),
        .rst   (rst),
        .load  (reload),
        .a_eff (a_eff),
        .phase (phase)
    );

    // error flag follows the program captured at each reload
    always_ff @(posedge clk_fin) begin
        if (rst || reload) begin
            err_q <= a_over;
        end
    end

    assign mod_ctl     = phase_to_pin(phase);
    assign fb_pulse    = reload;
    assign swallow_err = err_q;
endmodule

// File: rtl/dual_mod_ctrl_checks.sv
module dual_mod_ctrl_checks #(
    parameter int N_W = 10,
    parameter int A_W = 6
) (
    input logic           clk,
    input logic           rst,
    input logic [N_W-1:0] n_prog,
    input logic [A_W-1:0] a_prog,
    input logic           mc,
    input logic           fv,
    input logic           err
);
    logic over;
    assign over = (int'(a_prog) > int'(n_prog));

    // R1: feedback pulse lasts one period
    a_r1_fv_one_period: assert property (@(posedge clk) disable iff (rst)
        fv |=> !fv);

    // R2: once high, modulus select holds until the cycle ends
    a_r2_mc_holds_high: assert property (@(posedge clk) disable iff (rst)
        (mc && !fv) |=> mc);

    // R3: zero swallow count starts the cycle with modulus P
    a_r3_zero_swallow_high: assert property (@(posedge clk) disable iff (rst)
        (fv && a_prog == '0) |=> mc);

    // R6: swallow count at or above N starts the cycle at P+1
    a_r6_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (fv && int'(a_prog) >= int'(n_prog)) |=> !mc);

    // R6: error flag captured at reload
    a_r6_err_at_reload: assert property (@(posedge clk) disable iff (rst)
        fv |=> (err == $past(over)));

    // R5: flag does not move inside a cycle
    a_r5_err_stable: assert property (@(posedge clk) disable iff (rst)
        !fv |=> $stable(err));
endmodule

bind dual_mod_ctrl dual_mod_ctrl_checks #(.N_W(N_W), .A_W(A_W)) u_checks (
    .clk    (clk_fin),
    .rst    (rst),
    .n_prog (n_prog),
    .a_prog (a_prog),
    .mc     (mod_ctl),
    .fv     (fb_pulse),
    .err    (swallow_err)
);

// File: tb/test_dual_mod_ctrl.sv
`timescale 1ns/1ps
module test_dual_mod_ctrl;
    logic       vin = 1'b0;   // oscillator, 100 MHz
    logic       fin = 1'b0;   // prescaler output
    logic       rst = 1'b1;
    logic [9:0] n_in = 10'd10;
    logic [5:0] a_in = 6'd3;
    logic       mc, fv, err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int ps_p = 8;
    int ps_cnt = 3;

    // monitor state
    int  vcnt = 0, lowc = 0, hic = 0, fvc = 0, bnd = 0;
    bit  armed = 0, prev_fv = 0, r5_watch = 0;
    int  exp_n = 10, exp_a = 3;
    bit  exp_over = 0;
    int  nxt_n = 10, nxt_a = 3;
    bit  nxt_over = 0;

    always #5 vin = ~vin;

    dual_mod_ctrl i_dual_mod_ctrl (
        .clk_fin     (fin),
        .rst         (rst),
        .n_prog      (n_in),
        .a_prog      (a_in),
        .mod_ctl     (mc),
        .fb_pulse    (fv),
        .swallow_err (err)
    );

    // behavioural P/P+1 prescaler: mc low -> P+1, mc high -> P
    always @(posedge vin) begin
        if (fin) begin
            fin <= 1'b0;
            ps_cnt <= (mc ? ps_p : ps_p + 1) - 2;
        end else if (ps_cnt == 0) begin
            fin <= 1'b1;
        end else begin
            ps_cnt <= ps_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic string tag_of(input int n, input int a, input bit ov);
        if (r5_watch) return "R5";
        if (ov) return "R6";
        if (a == 0) return "R3";
        return "R2";
    endfunction

    always @(negedge vin) begin
        if (rst) begin
            armed = 0; vcnt = 0; lowc = 0; hic = 0; fvc = 0; prev_fv = 0;
        end else begin
            vcnt++;
            if (fin) begin
                if (prev_fv && !fv) begin
                    if (armed) begin
                        chk(vcnt == exp_n * ps_p + exp_a, r5_watch ? "R5" : "R4",
                            "oscillator cycles per cycle", vcnt, exp_n * ps_p + exp_a);
                        chk(lowc == exp_a, tag_of(exp_n, exp_a, exp_over),
                            "periods with mc low", lowc, exp_a);
                        chk(hic == exp_n - exp_a, tag_of(exp_n, exp_a, exp_over),
                            "periods with mc high", hic, exp_n - exp_a);
                        chk(fvc == 1, "R1", "periods with fv high", fvc, 1);
                        r5_watch = 0;
                    end
                    armed = 1;
                    exp_n = nxt_n; exp_a = nxt_a; exp_over = nxt_over;
                    chk(err == nxt_over, "R6", "swallow_err after reload",
                        int'(err), int'(nxt_over));
                    bnd++;
                    vcnt = 0; lowc = 0; hic = 0; fvc = 0;
                end
                lowc += int'(!mc);
                hic  += int'(mc);
                fvc  += int'(fv);
                prev_fv = fv;
            end
        end
    end

    task automatic set_prog(input int n, input int a, input int p);
        @(negedge vin);
        while (fin) @(negedge vin);
        n_in = 10'(n);
        a_in = 6'(a);
        nxt_n = n;
        nxt_a = (a > n) ? n : a;
        nxt_over = (a > n);
        if (p != ps_p) begin
            ps_p = p;
            armed = 0;
        end
    endtask

    task automatic run_prog(input int n, input int a, input int p, input int ncyc);
        int b0;
        set_prog(n, a, p);
        b0 = bnd;
        while (bnd < b0 + ncyc) @(negedge vin);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge vin) begin
        cyc++;
        if (cyc == 190000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        // R7: reset holds loaded state
        repeat (20) @(negedge vin);
        chk(fv == 1'b0, "R7", "fv in reset", int'(fv), 0);
        chk(mc == 1'b0, "R7", "mc in reset with A=3", int'(mc), 0);
        chk(err == 1'b0, "R7", "err in reset", int'(err), 0);
        a_in = 6'd0;
        repeat (20) @(negedge vin);
        chk(mc == 1'b1, "R7", "mc in reset with A=0", int'(mc), 1);
        a_in = 6'd12;
        repeat (20) @(negedge vin);
        chk(err == 1'b1, "R7", "err in reset with A>N", int'(err), 1);
        chk(fv == 1'b0, "R7", "fv in reset with A>N", int'(fv), 0);
        a_in = 6'd3;
        nxt_n = 10; nxt_a = 3; nxt_over = 0;
        repeat (20) @(negedge vin);
        rst = 1'b0;

        run_prog(10, 3, 8, 2);

        // near-exhaustive sweep of small programs, P = 8
        for (int n = 3; n <= 8; n++) begin
            for (int a = 0; a <= n + 1; a++) begin
                run_prog(n, a, 8, 2);
            end
        end

        // R5: program changed in the middle of a cycle
        run_prog(20, 5, 8, 2);
        repeat (40) @(negedge vin);
        r5_watch = 1;
        run_prog(9, 9, 8, 2);

        // R4 with P = 64
        run_prog(100, 37, 64, 3);
        // range limits with P = 4
        run_prog(1023, 63, 4, 3);
        run_prog(1023, 0, 4, 2);
        run_prog(3, 63, 4, 2);

        finish_run();
    end
endmodule